// File: doc/BRIEF.md
# Hopping-Access Branch Target Buffer

This block is the branch target buffer of a single-issue fetch stage that fetches one 32-bit instruction per accepted cycle. Alongside its tag, target and 2-bit direction counter, each entry keeps a short count of how many instructions separate that branch from the branch that followed it on the executed path. When a fetch hits an entry that predicts taken, a countdown loaded from that count turns off the array reads for the straight-line fetches that cannot be branches. The array is therefore read only where a branch is expected.

The execute stage reports every resolved branch on the resolve port: its PC, direction and target, plus a redirect flag when fetch has to be steered again. The block derives the distance from the PCs of two consecutive resolved branches and writes it into the entry of the earlier branch. A taken branch that missed is allocated with an unknown distance. A lookup counter gives the number of array reads, so that it can be compared with the number of fetches for power estimation.

Top module: `hop_btb`

## Requirements
- R1: A resolved taken branch whose PC misses allocates the entry at index PC[8:2]. The entry is valid, holds tag PC[31:9] and the given target, has its counter set to weakly taken (2'b10), and has distance 0.
- R2: A fetch hits only when the entry at PC[8:2] is valid and its tag equals PC[31:9]. A PC that aliases the index under another tag misses.
- R3: The prediction is taken when the counter MSB is 1. Each resolve of a hitting branch steps the counter by one, saturating at 0 and 3, upward when taken and downward when not taken. A taken resolve also rewrites the target.
- R4: On each resolve that follows an earlier resolve, the distance is d = (PC - S)/4 + 1. S is the earlier branch's target if it was taken, and its PC + 4 if not. The value d is written into the entry of the earlier branch, but only while that entry still holds the earlier branch.
- R5: A fetch that hits with a taken prediction and a non-zero distance d disables lookups for the next d-1 accepted fetches. The d-th accepted fetch performs a lookup.
- R6: A hit predicted not taken starts no skip, so the next fetch performs a lookup.
- R7: While fetch is stalled, the skip countdown holds its value.
- R8: A resolve with the redirect flag clears the countdown, so the next accepted fetch performs a lookup.
- R9: Distance 0 means unknown and causes no skip. A computed distance above 63, or a branch PC below S, is stored as 0. A distance of 63 gives the full 62-fetch skip.
- R10: The lookup counter increments in exactly the cycles in which the array is read, that is, the accepted fetches outside a skip.
- R11: During a skipped fetch, the hit, taken and target outputs are all 0.
- R12: After reset all entries are invalid, the countdown is zero and the lookup counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | A fetch is accepted this cycle |
| fetch_pc | input | 32 | PC of the fetch |
| lookup_en | output | 1 | The array is read this cycle |
| pred_hit | output | 1 | The fetch PC hit a valid entry |
| pred_taken | output | 1 | The hit predicts taken |
| pred_target | output | 32 | Predicted target, 0 when there is no hit |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | 32 | Actual target of the resolved branch |
| res_redirect | input | 1 | Execute steers fetch again (mispredict) |
| lookup_count | output | 32 | Number of array reads since reset |

## Verification
The bench aims at the points where a skip starts and ends. It checks that the d-th fetch after a taken hit is looked up: a countdown that is off by one would either swallow the next branch or read the array for one wasted cycle. It stalls fetch in the middle of a skip, which exposes a countdown that runs on cycles instead of on fetches. It raises a redirect part way through a skip, which exposes a block that goes on skipping down the corrected path. It also covers a distance of 63, a distance of 65 that must clamp to 0, a not-taken hit that must start no skip, and an aliasing PC that must miss. The lookup counter is compared with the number of reads the bench expects, which catches counting during skipped or stalled cycles.

// File: rtl/hop_btb_pkg.sv
package hop_btb_pkg;

   localparam logic [1:0] CTR_WEAK_TAKEN = 2'b10;

   function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
      if (up) return (c == 2'b11) ? c : c + 2'b01;
      else    return (c == 2'b00) ? c : c - 2'b01;
   endfunction

endpackage

// File: rtl/hop_btb_array.sv
module hop_btb_array
   import hop_btb_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int IDX_W  = 7,
   parameter int DIST_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PC_W-1:0]   rd_pc,
   output logic              rd_hit,
   output logic [1:0]        rd_ctr,
   output logic [PC_W-1:0]   rd_target,
   output logic [DIST_W-1:0] rd_dist,
   input  logic              up_valid,
   input  logic [PC_W-1:0]   up_pc,
   input  logic              up_taken,
   input  logic [PC_W-1:0]   up_target,
   input  logic              dw_en,
   input  logic [PC_W-1:0]   dw_pc,
   input  logic [DIST_W-1:0] dw_dist
);

   localparam int ENTRIES = 1 << IDX_W;
   localparam int TAG_W   = PC_W - IDX_W - 2;

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [PC_W-1:0]    tgt_q  [ENTRIES];
   logic [1:0]         ctr_q  [ENTRIES];
   logic [DIST_W-1:0]  dist_q [ENTRIES];

   logic [IDX_W-1:0] rd_idx, up_idx, dw_idx;
   logic [TAG_W-1:0] rd_tag, up_tag, dw_tag;
   logic             up_hit, alloc, dw_ok;

   assign rd_idx = rd_pc[IDX_W+1:2];
   assign rd_tag = rd_pc[PC_W-1:IDX_W+2];
   assign up_idx = up_pc[IDX_W+1:2];
   assign up_tag = up_pc[PC_W-1:IDX_W+2];
   assign dw_idx = dw_pc[IDX_W+1:2];
   assign dw_tag = dw_pc[PC_W-1:IDX_W+2];

   assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_ctr    = ctr_q[rd_idx];
   assign rd_target = tgt_q[rd_idx];
   assign rd_dist   = dist_q[rd_idx];

   assign up_hit = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
   assign alloc  = up_valid && !up_hit && up_taken;
   assign dw_ok  = dw_en && valid_q[dw_idx] && (tag_q[dw_idx] == dw_tag)
                   && !(alloc && (up_idx == dw_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else if (alloc) valid_q[up_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (up_valid && up_hit) begin
         ctr_q[up_idx] <= ctr_step(ctr_q[up_idx], up_taken);
         if (up_taken) tgt_q[up_idx] <= up_target;
      end else if (alloc) begin
         tag_q[up_idx]  <= up_tag;
         tgt_q[up_idx]  <= up_target;
         ctr_q[up_idx]  <= CTR_WEAK_TAKEN;
         dist_q[up_idx] <= '0;
      end
      if (dw_ok) dist_q[dw_idx] <= dw_dist;
   end

endmodule

// File: rtl/hop_dist_calc.sv
module hop_dist_calc #(
   parameter int PC_W   = 32,
   parameter int DIST_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [PC_W-1:0]   res_pc,
   input  logic              res_taken,
   input  logic [PC_W-1:0]   res_target,
   output logic              dw_en,
   output logic [PC_W-1:0]   dw_pc,
   output logic [DIST_W-1:0] dw_dist
);

   localparam logic [PC_W-3:0] LIMIT = (PC_W-2)'((1 << DIST_W) - 1);

   logic            prev_valid;
   logic [PC_W-1:0] prev_pc, prev_next;
   logic [PC_W-1:0] diff;
   logic [PC_W-3:0] words;

   assign diff  = res_pc - prev_next;
   assign words = diff[PC_W-1:2];
   assign dw_en = res_valid && prev_valid;
   assign dw_pc = prev_pc;

   always_comb begin
      if ((res_pc < prev_next) || (words >= LIMIT)) dw_dist = '0;
      else dw_dist = words[DIST_W-1:0] + DIST_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_valid <= 1'b0;
         prev_pc    <= '0;
         prev_next  <= '0;
      end else if (res_valid) begin
         prev_valid <= 1'b1;
         prev_pc    <= res_pc;
         prev_next  <= res_taken ? res_target : res_pc + PC_W'(4);
      end
   end

endmodule

// File: rtl/hop_skip_ctr.sv
module hop_skip_ctr #(
   parameter int DIST_W = 6,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_valid,
   input  logic              redirect,
   input  logic              hit_taken,
   input  logic [DIST_W-1:0] hit_dist,
   output logic              lookup_en,
   output logic [DIST_W-1:0] skip_cnt,
   output logic [CNT_W-1:0]  lookup_count
);

   assign lookup_en = fetch_valid && (skip_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_cnt     <= '0;
         lookup_count <= '0;
      end else begin
         if (redirect)
            skip_cnt <= '0;
         else if (lookup_en && hit_taken && (hit_dist != '0))
            skip_cnt <= hit_dist - DIST_W'(1);
         else if (fetch_valid && (skip_cnt != '0))
            skip_cnt <= skip_cnt - DIST_W'(1);
         if (lookup_en) lookup_count <= lookup_count + CNT_W'(1);
      end
   end

endmodule

// File: rtl/hop_btb.sv
module hop_btb #(
   parameter int PC_W    = 32,
   parameter int ENTRIES = 128,
   parameter int DIST_W  = 6,
   parameter int CNT_W   = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_valid,
   input  logic [PC_W-1:0]  fetch_pc,
   output logic             lookup_en,
   output logic             pred_hit,
   output logic             pred_taken,
   output logic [PC_W-1:0]  pred_target,
   input  logic             res_valid,
   input  logic [PC_W-1:0]  res_pc,
   input  logic             res_taken,
   input  logic [PC_W-1:0]  res_target,
   input  logic             res_redirect,
   output logic [CNT_W-1:0] lookup_count
);

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int TAG_W = PC_W - IDX_W - 2;

   if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("PC_W too narrow for ENTRIES");
   end
   if (DIST_W < 1 || DIST_W > PC_W - 2) begin : g_bad_dist
      $error("DIST_W out of range");
   end

   logic              rd_hit;
   logic [1:0]        rd_ctr;
   logic [PC_W-1:0]   rd_target;
   logic [DIST_W-1:0] rd_dist;
   logic              dw_en;
   logic [PC_W-1:0]   dw_pc;
   logic [DIST_W-1:0] dw_dist;
   logic [DIST_W-1:0] skip_cnt;
   logic              redirect;

   assign redirect    = res_valid && res_redirect;
   assign pred_hit    = lookup_en && rd_hit;
   assign pred_taken  = pred_hit && rd_ctr[1];
   assign pred_target = pred_hit ? rd_target : '0;

   hop_btb_array #(.PC_W(PC_W), .IDX_W(IDX_W), .DIST_W(DIST_W)) u_array (
      .clk, .rst_n,
      .rd_pc(fetch_pc), .rd_hit, .rd_ctr, .rd_target, .rd_dist,
      .up_valid(res_valid), .up_pc(res_pc), .up_taken(res_taken),
      .up_target(res_target),
      .dw_en, .dw_pc, .dw_dist
   );

   hop_dist_calc #(.PC_W(PC_W), .DIST_W(DIST_W)) u_dist (
      .clk, .rst_n, .res_valid, .res_pc, .res_taken, .res_target,
      .dw_en, .dw_pc, .dw_dist
   );

   hop_skip_ctr #(.DIST_W(DIST_W), .CNT_W(CNT_W)) u_skip (
      .clk, .rst_n, .fetch_valid, .redirect,
      .hit_taken(pred_taken), .hit_dist(rd_dist),
      .lookup_en, .skip_cnt, .lookup_count
   );

endmodule

// File: rtl/hop_btb_chk.sv
module hop_btb_chk #(
   parameter int DIST_W = 6,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_valid,
   input logic              lookup_en,
   input logic              pred_hit,
   input logic              pred_taken,
   input logic              res_valid,
   input logic              res_redirect,
   input logic [CNT_W-1:0]  lookup_count,
   input logic [DIST_W-1:0] skip_cnt,
   input logic [DIST_W-1:0] rd_dist
);

   // R11
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_en |-> !pred_hit);

   // R3
   taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_taken |-> pred_hit);

   // R10
   lookup_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_en |=> lookup_count == $past(lookup_count) + CNT_W'(1));

   // R10
   no_tally_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_en |=> $stable(lookup_count));

   // R8
   redirect_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_redirect) |=> (skip_cnt == '0));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_valid && !(res_valid && res_redirect)) |=> $stable(skip_cnt));

   // R6
   nt_noskip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_valid && pred_hit && !pred_taken && !(res_valid && res_redirect))
      |=> (skip_cnt == '0));

   // R5
   skip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken && (rd_dist != '0) && !(res_valid && res_redirect))
      |=> (skip_cnt == $past(rd_dist) - DIST_W'(1)));

endmodule

bind hop_btb hop_btb_chk #(.DIST_W(DIST_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .lookup_en(lookup_en),
   .pred_hit(pred_hit), .pred_taken(pred_taken), .res_valid(res_valid),
   .res_redirect(res_redirect), .lookup_count(lookup_count),
   .skip_cnt(skip_cnt), .rd_dist(rd_dist)
);

// File: tb/tb_hop_btb.sv
module tb_hop_btb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        lookup_en, pred_hit, pred_taken;
   logic [31:0] pred_target;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic [31:0] res_target = '0;
   logic        res_redirect = 1'b0;
   logic [31:0] lookup_count;

   int total = 0;
   int fails = 0;
   int exp_lookups = 0;

   typedef struct {
      logic        hit;
      logic        taken;
      logic [31:0] tgt;
      logic        en;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   hop_btb dut (
      .clk, .rst_n, .fetch_valid, .fetch_pc, .lookup_en, .pred_hit,
      .pred_taken, .pred_target, .res_valid, .res_pc, .res_taken,
      .res_target, .res_redirect, .lookup_count
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic fetch(input logic [31:0] pc, input logic hit, input logic tk,
                        input logic [31:0] tgt, input logic en, input string req);
      exp_t e;
      @(posedge clk); #1;
      res_valid   = 1'b0;
      fetch_valid = 1'b1;
      fetch_pc    = pc;
      e.hit = hit; e.taken = tk; e.tgt = tgt; e.en = en; e.req = req;
      sb.push_back(e);
      if (en) exp_lookups++;
   endtask

   task automatic resolve(input logic [31:0] pc, input logic tk,
                          input logic [31:0] tgt, input logic redir);
      @(posedge clk); #1;
      fetch_valid  = 1'b0;
      res_valid    = 1'b1;
      res_pc       = pc;
      res_taken    = tk;
      res_target   = tgt;
      res_redirect = redir;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      fetch_valid = 1'b0;
      res_valid   = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         check(lookup_en == e.en && pred_hit == e.hit && pred_taken == e.taken
               && pred_target == e.tgt, e.req,
               $sformatf("pc=%h en/hit/taken", fetch_pc),
               {lookup_en, pred_hit, pred_taken, pred_target[28:0]},
               {e.en, e.hit, e.taken, e.tgt[28:0]});
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1 check(lookup_count == 0, "R12", "lookup_count after reset", lookup_count, 0);
      fetch(32'h100, 0, 0, 0, 1, "R12");              // empty buffer misses
      resolve(32'h100, 1, 32'h200, 0);                // A allocated
      fetch(32'h100, 1, 1, 32'h200, 1, "R1");
      fetch(32'h104, 0, 0, 0, 1, "R1");               // distance 0: no skip
      resolve(32'h210, 1, 32'h300, 0);                // B allocated, A dist 5
      fetch(32'h100, 1, 1, 32'h200, 1, "R4");         // loads 4
      idle(); idle();                                 // stall mid-skip
      fetch(32'h200, 0, 0, 0, 0, "R7");
      fetch(32'h204, 0, 0, 0, 0, "R11");
      fetch(32'h208, 0, 0, 0, 0, "R5");
      fetch(32'h20c, 0, 0, 0, 0, "R5");
      fetch(32'h210, 1, 1, 32'h300, 1, "R5");         // 5th fetch looked up
      fetch(32'h300, 0, 0, 0, 1, "R2");               // alias of A's index
      idle();
      #1 check(lookup_count == exp_lookups, "R10", "lookup_count", lookup_count, exp_lookups);
      // redirect mid-skip
      fetch(32'h100, 1, 1, 32'h200, 1, "R5");
      fetch(32'h200, 0, 0, 0, 0, "R8");
      resolve(32'h210, 1, 32'h300, 1);
      fetch(32'h210, 1, 1, 32'h300, 1, "R8");
      // not-taken hit
      resolve(32'h100, 0, 32'h200, 0);                // A counter 10 -> 01
      fetch(32'h100, 1, 0, 32'h200, 1, "R3");
      fetch(32'h104, 0, 0, 0, 1, "R6");
      resolve(32'h100, 1, 32'h200, 0);                // back to 10, A dist 0
      fetch(32'h100, 1, 1, 32'h200, 1, "R3");
      fetch(32'h200, 0, 0, 0, 1, "R9");
      // over-range distance
      resolve(32'h404, 1, 32'h1008, 0);               // C
      resolve(32'h1108, 1, 32'h2000, 0);              // D, C dist 65 -> 0
      fetch(32'h404, 1, 1, 32'h1008, 1, "R9");
      fetch(32'h1008, 0, 0, 0, 1, "R9");
      // maximum distance
      resolve(32'h2008, 1, 32'h3000, 0);              // E, D dist 3
      resolve(32'h30f8, 1, 32'h100, 0);               // F, E dist 63
      fetch(32'h2008, 1, 1, 32'h3000, 1, "R9");
      for (int i = 0; i < 62; i++)
         fetch(32'h3000 + 32'(4 * i), 0, 0, 0, 0, "R9");
      fetch(32'h30f8, 1, 1, 32'h100, 1, "R9");
      // short distance then redirect
      fetch(32'h1108, 1, 1, 32'h2000, 1, "R4");
      fetch(32'h2000, 0, 0, 0, 0, "R4");
      fetch(32'h2004, 0, 0, 0, 0, "R4");
      fetch(32'h2008, 1, 1, 32'h3000, 1, "R4");
      resolve(32'h2008, 1, 32'h3000, 1);
      fetch(32'h3000, 0, 0, 0, 1, "R8");
      idle(); idle();
      #1 check(lookup_count == exp_lookups, "R10", "lookup_count final", lookup_count, exp_lookups);
      check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule